// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is a small control unit placed beside a processor core's program counter and status register. When a hardware interrupt request or a software-interrupt trigger is accepted, it raises a stall output. It saves the interrupted return address and the full status word on a memory stack, then loads a handler address that it computes itself into the PC. In the same cycle it loads a status word with the supervisor mode bit set and the interrupt-enable bit cleared.

A return command reverses the sequence. Two pops bring back the saved status word and return address, and both are loaded into the core unchanged. The interrupted program therefore resumes in user mode with its original status.

The stack pointer starts at a top address and grows downward. Each stack access takes one cycle on a simple port with combinational read data. Entries may nest, and saved frames come back in last-in, first-out order.

Top module: `trapSequencer`

## Requirements
- R1: After reset, busy, stkWrEn, stkRdEn, pcLoad and statusLoad are all low, and the stack pointer equals STACK_TOP.
- R2: A hardware request (irqReq) seen while idle is accepted only if bit IE_BIT (bit 1) of curStatus is 1. From the next cycle, busy stays high for exactly three cycles.
- R3: For an accepted hardware request, the PC load value is IRQ_BASE + irqId*4.
- R4: A software trigger (swiReq) is accepted whatever the value of the enable bit, and its handler is SWI_BASE + swiNum*4. When swiReq and irqReq arrive together, the software trigger wins.
- R5: Entry pushes with pre-decrement. In the first busy cycle, the return address is written at SP-1. In the second, the captured status word is written at SP-2.
- R6: In the third entry cycle, pcLoad and statusLoad pulse together. The status value is the captured word with bit MODE_BIT (bit 0, 1 = supervisor) set, bit 1 cleared and all other bits unchanged.
- R7: On retReq, the block reads the status word at SP in the first busy cycle and the return address at SP+1 in the second. In the third it loads both unchanged, and the stack pointer ends two above its value before the return.
- R8: Any irqReq, swiReq or retReq raised while busy is high is ignored.
- R9: irqReq is ignored while curStatus bit 1 is 0, so no stack write and no busy follow.
- R10: Nested entries are unwound in last-in, first-out order. Each return restores the PC and status that the matching entry saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Hardware interrupt request |
| irqId | input | ID_W | Hardware interrupt number |
| swiReq | input | 1 | Software interrupt trigger |
| swiNum | input | ID_W | Software interrupt number |
| retReq | input | 1 | Return-from-interrupt command |
| curPc | input | DW | Current program counter (return address) |
| curStatus | input | DW | Current status register |
| busy | output | 1 | Core stall while a sequence runs |
| stkAddr | output | AW | Stack memory address |
| stkWrEn | output | 1 | Stack write strobe |
| stkWrData | output | DW | Stack write data |
| stkRdEn | output | 1 | Stack read strobe |
| stkRdData | input | DW | Stack read data, valid in the cycle of stkRdEn |
| pcLoad | output | 1 | Load strobe for the PC |
| pcValue | output | DW | New PC value |
| statusLoad | output | 1 | Load strobe for the status register |
| statusValue | output | DW | New status value |

## Verification
The assertions assume that the stack memory returns read data in the same cycle as the read strobe. They also assume that the core applies pcLoad and statusLoad at the next edge, so curPc and curStatus reflect a sequence only after it ends. The bench builds a combinational memory model and a core model that does exactly this. Requests are raised only on falling edges and are either held for a single cycle or held deliberately through a busy window. Return commands are only issued when a saved frame exists, so the stack never underflows.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef struct packed {
    logic capture;
    logic useSwi;
    logic pushPc;
    logic pushSt;
    logic popSt;
    logic popPc;
    logic loadEntry;
    logic loadReturn;
  } trapStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PC, ST_PUSH_ST, ST_ENTER, ST_POP_ST, ST_POP_PC, ST_RESUME
  } trapState_t;
endpackage

// File: rtl/trapCtrl.sv
module trapCtrl
  import trap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         irqReq,
  input  logic         swiReq,
  input  logic         retReq,
  input  logic         ieBit,
  output trapStrobes_t strobes,
  output logic         busy
);
  trapState_t state, nextState;

  logic takeSwi, takeRet, takeIrq;

  always_comb begin
    takeSwi = (state == ST_IDLE) && swiReq;
    takeRet = (state == ST_IDLE) && !swiReq && retReq;
    takeIrq = (state == ST_IDLE) && !swiReq && !retReq && irqReq && ieBit;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (takeSwi || takeIrq) nextState = ST_PUSH_PC;
        else if (takeRet)       nextState = ST_POP_ST;
      end
      ST_PUSH_PC: nextState = ST_PUSH_ST;
      ST_PUSH_ST: nextState = ST_ENTER;
      ST_ENTER:   nextState = ST_IDLE;
      ST_POP_ST:  nextState = ST_POP_PC;
      ST_POP_PC:  nextState = ST_RESUME;
      ST_RESUME:  nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobes            = '0;
    strobes.capture    = takeSwi || takeIrq;
    strobes.useSwi     = takeSwi;
    strobes.pushPc     = (state == ST_PUSH_PC);
    strobes.pushSt     = (state == ST_PUSH_ST);
    strobes.loadEntry  = (state == ST_ENTER);
    strobes.popSt      = (state == ST_POP_ST);
    strobes.popPc      = (state == ST_POP_PC);
    strobes.loadReturn = (state == ST_RESUME);
  end

  assign busy = (state != ST_IDLE);

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.capture) else $error("capture while busy"); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.useSwi) |-> ieBit) else $error("irq taken with IE clear"); // R9
  AST_ENTRY_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> busy ##1 busy ##1 busy ##1 !busy) else $error("entry length"); // R2
  AST_SWI_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swiReq) |-> strobes.useSwi) else $error("swi lost priority"); // R4
endmodule

// File: rtl/trapDatapath.sv
module trapDatapath
  import trap_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int ID_W      = 4,
  parameter int MODE_BIT  = 0,
  parameter int IE_BIT    = 1,
  parameter logic [DW-1:0] IRQ_BASE  = 32'h0000_0100,
  parameter logic [DW-1:0] SWI_BASE  = 32'h0000_0200,
  parameter logic [AW-1:0] STACK_TOP = 16'h0080
)(
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobes_t    strobes,
  input  logic [ID_W-1:0] irqId,
  input  logic [ID_W-1:0] swiNum,
  input  logic [DW-1:0]   curPc,
  input  logic [DW-1:0]   curStatus,
  output logic [AW-1:0]   stkAddr,
  output logic            stkWrEn,
  output logic [DW-1:0]   stkWrData,
  output logic            stkRdEn,
  input  logic [DW-1:0]   stkRdData,
  output logic            pcLoad,
  output logic [DW-1:0]   pcValue,
  output logic            statusLoad,
  output logic [DW-1:0]   statusValue
);
  localparam int OFS_W = ID_W + 2;

  logic [AW-1:0]   sp;
  logic [DW-1:0]   savedPc, savedSt, vecAddr;
  logic [ID_W-1:0] pickedId;
  logic [DW-1:0]   idOffset, entryStatus;

  always_comb begin
    pickedId    = strobes.useSwi ? swiNum : irqId;
    idOffset    = DW'({pickedId, 2'b00});
    entryStatus = savedSt;
    entryStatus[MODE_BIT] = 1'b1;
    entryStatus[IE_BIT]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp      <= STACK_TOP;
      savedPc <= '0;
      savedSt <= '0;
      vecAddr <= '0;
    end else begin
      if (strobes.capture) begin
        savedPc <= curPc;
        savedSt <= curStatus;
        vecAddr <= (strobes.useSwi ? SWI_BASE : IRQ_BASE) + idOffset;
      end
      if (strobes.pushPc || strobes.pushSt) sp <= sp - AW'(1);
      if (strobes.popSt) begin
        savedSt <= stkRdData;
        sp      <= sp + AW'(1);
      end
      if (strobes.popPc) begin
        savedPc <= stkRdData;
        sp      <= sp + AW'(1);
      end
    end
  end

  always_comb begin
    stkWrEn     = strobes.pushPc || strobes.pushSt;
    stkRdEn     = strobes.popSt || strobes.popPc;
    stkAddr     = stkWrEn ? (sp - AW'(1)) : sp;
    stkWrData   = strobes.pushPc ? savedPc : savedSt;
    pcLoad      = strobes.loadEntry || strobes.loadReturn;
    statusLoad  = pcLoad;
    pcValue     = strobes.loadEntry ? vecAddr : savedPc;
    statusValue = strobes.loadEntry ? entryStatus : savedSt;
  end

  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(stkWrEn && stkRdEn)) else $error("read and write together"); // R5
  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushPc |=> (stkWrEn && stkAddr == $past(stkAddr) - AW'(1))) else $error("push order"); // R5
  AST_POP_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popSt |=> (stkRdEn && stkAddr == $past(stkAddr) + AW'(1))) else $error("pop order"); // R7
  AST_ENTRY_SUPERVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEntry |-> (statusValue[MODE_BIT] && !statusValue[IE_BIT])) else $error("entry mode"); // R6
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popPc |=> (pcLoad && pcValue == $past(stkRdData))) else $error("return pc"); // R7
endmodule

// File: rtl/trapSequencer.sv
module trapSequencer
  import trap_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int ID_W      = 4,
  parameter int MODE_BIT  = 0,
  parameter int IE_BIT    = 1,
  parameter logic [DW-1:0] IRQ_BASE  = 32'h0000_0100,
  parameter logic [DW-1:0] SWI_BASE  = 32'h0000_0200,
  parameter logic [AW-1:0] STACK_TOP = 16'h0080
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic [ID_W-1:0] irqId,
  input  logic            swiReq,
  input  logic [ID_W-1:0] swiNum,
  input  logic            retReq,
  input  logic [DW-1:0]   curPc,
  input  logic [DW-1:0]   curStatus,
  output logic            busy,
  output logic [AW-1:0]   stkAddr,
  output logic            stkWrEn,
  output logic [DW-1:0]   stkWrData,
  output logic            stkRdEn,
  input  logic [DW-1:0]   stkRdData,
  output logic            pcLoad,
  output logic [DW-1:0]   pcValue,
  output logic            statusLoad,
  output logic [DW-1:0]   statusValue
);
  trapStrobes_t strobes;

  trapCtrl uCtrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .swiReq(swiReq), .retReq(retReq),
    .ieBit(curStatus[IE_BIT]), .strobes(strobes), .busy(busy)
  );

  trapDatapath #(
    .DW(DW), .AW(AW), .ID_W(ID_W), .MODE_BIT(MODE_BIT), .IE_BIT(IE_BIT),
    .IRQ_BASE(IRQ_BASE), .SWI_BASE(SWI_BASE), .STACK_TOP(STACK_TOP)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqId(irqId), .swiNum(swiNum),
    .curPc(curPc), .curStatus(curStatus), .stkAddr(stkAddr), .stkWrEn(stkWrEn),
    .stkWrData(stkWrData), .stkRdEn(stkRdEn), .stkRdData(stkRdData),
    .pcLoad(pcLoad), .pcValue(pcValue), .statusLoad(statusLoad), .statusValue(statusValue)
  );
endmodule

// File: tb/trapSequencer_test.sv
module trapSequencer_test;
  logic clk = 0, rstN = 0;
  logic irqReq = 0, swiReq = 0, retReq = 0;
  logic [3:0] irqId = 0, swiNum = 0;
  logic [31:0] curPc, curStatus;
  logic busy, stkWrEn, stkRdEn, pcLoad, statusLoad;
  logic [15:0] stkAddr;
  logic [31:0] stkWrData, stkRdData, pcValue, statusValue;
  logic [31:0] mem [0:255];

  int checks = 0, errors = 0;
  logic [15:0] expSp = 16'h0080;
  logic [31:0] framePc [0:7];
  logic [31:0] frameSt [0:7];
  int depth = 0;

  always #4 clk = ~clk;

  trapSequencer uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqId(irqId), .swiReq(swiReq),
    .swiNum(swiNum), .retReq(retReq), .curPc(curPc), .curStatus(curStatus),
    .busy(busy), .stkAddr(stkAddr), .stkWrEn(stkWrEn), .stkWrData(stkWrData),
    .stkRdEn(stkRdEn), .stkRdData(stkRdData), .pcLoad(pcLoad), .pcValue(pcValue),
    .statusLoad(statusLoad), .statusValue(statusValue)
  );

  assign stkRdData = mem[stkAddr[7:0]];
  always @(posedge clk) if (stkWrEn) mem[stkAddr[7:0]] <= stkWrData;
  always @(posedge clk) begin
    if (pcLoad) curPc <= pcValue;
    if (statusLoad) curStatus <= statusValue;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doEntry(input bit viaSwi, input bit bothReq, input logic [3:0] id, input bit holdSwi);
    logic [31:0] expVec, pc0, st0, expSt;
    pc0 = curPc; st0 = curStatus;
    expVec = (viaSwi ? 32'h200 : 32'h100) + {26'd0, id, 2'b00};
    expSt = (st0 | 32'h1) & ~32'h2;
    @(negedge clk);
    if (viaSwi) begin swiReq = 1; swiNum = id; end
    if (!viaSwi || bothReq) begin irqReq = 1; irqId = bothReq ? ~id : id; end
    @(negedge clk);
    irqReq = 0; swiReq = holdSwi; retReq = holdSwi;
    chk(busy, "R2 busy cycle1", {31'd0, busy}, 1);
    chk(stkWrEn && stkAddr == expSp - 1, "R5 push pc addr", {16'd0, stkAddr}, {16'd0, expSp - 16'd1});
    chk(stkWrData == pc0, "R5 push pc data", stkWrData, pc0);
    @(negedge clk);
    chk(stkWrEn && stkAddr == expSp - 2, "R5 push status addr", {16'd0, stkAddr}, {16'd0, expSp - 16'd2});
    chk(stkWrData == st0, "R5 push status data", stkWrData, st0);
    @(negedge clk);
    chk(pcLoad && statusLoad && busy, "R6 load strobes", {29'd0, pcLoad, statusLoad, busy}, 3'b111);
    chk(pcValue == expVec, viaSwi ? "R4 swi vector" : "R3 irq vector", pcValue, expVec);
    chk(statusValue == expSt, "R6 supervisor status", statusValue, expSt);
    @(negedge clk);
    swiReq = 0; retReq = 0;
    chk(!busy, "R2 idle after three cycles", {31'd0, busy}, 0);
    if (holdSwi) begin
      @(negedge clk);
      chk(!busy && !stkWrEn && !stkRdEn, "R8 held requests ignored", {30'd0, stkWrEn, stkRdEn}, 0);
    end
    framePc[depth] = pc0; frameSt[depth] = st0; depth++;
    expSp = expSp - 2;
  endtask

  task automatic doReturn();
    depth--;
    @(negedge clk); retReq = 1;
    @(negedge clk); retReq = 0;
    chk(stkRdEn && stkAddr == expSp, "R7 pop status addr", {16'd0, stkAddr}, {16'd0, expSp});
    @(negedge clk);
    chk(stkRdEn && stkAddr == expSp + 1, "R7 pop pc addr", {16'd0, stkAddr}, {16'd0, expSp + 16'd1});
    @(negedge clk);
    chk(pcLoad && pcValue == framePc[depth], "R7 R10 restore pc", pcValue, framePc[depth]);
    chk(statusLoad && statusValue == frameSt[depth], "R7 R10 restore status", statusValue, frameSt[depth]);
    @(negedge clk);
    chk(!busy, "R7 idle after return", {31'd0, busy}, 0);
    expSp = expSp + 2;
  endtask

  task automatic testIgnoreDisabled();
    @(negedge clk); curStatus = 32'h0000_00A0; irqReq = 1; irqId = 4'd2;
    @(negedge clk); irqReq = 0;
    chk(!busy && !stkWrEn, "R9 irq ignored with IE clear", {30'd0, busy, stkWrEn}, 0);
    @(negedge clk);
    chk(!busy, "R9 still idle", {31'd0, busy}, 0);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        curPc = 32'h0000_1000; curStatus = 32'h0000_00A2;
        repeat (3) @(negedge clk);
        chk(!busy && !stkWrEn && !stkRdEn && !pcLoad && !statusLoad, "R1 reset outputs",
            {27'd0, busy, stkWrEn, stkRdEn, pcLoad, statusLoad}, 0);
        rstN = 1;
        doEntry(0, 0, 4'd3, 0);             // R2 R3 R5 R6
        curPc = 32'h0000_1004; curStatus = 32'h0000_00A3;
        curStatus = frameSt[0] | 32'h1 & ~32'h2;
        doReturn();                         // R7
        testIgnoreDisabled();               // R9
        curPc = 32'h0000_2000;
        doEntry(1, 0, 4'd5, 0);             // R4 IE clear, swi still taken
        doReturn();
        curStatus = 32'h0000_00A2; curPc = 32'h0000_3000;
        doEntry(1, 1, 4'd7, 0);             // R4 swi wins over irq
        doReturn();
        curStatus = 32'h0000_00A2; curPc = 32'h0000_4000;
        doEntry(0, 0, 4'd1, 1);             // R8
        doReturn();
        curStatus = 32'h0000_F0A2; curPc = 32'h0000_5000;
        doEntry(0, 0, 4'd15, 0);            // R3 highest id, R10 outer
        curPc = 32'h0000_013C;
        doEntry(1, 0, 4'd9, 0);             // R10 inner
        doReturn();
        doReturn();
        chk(curPc == 32'h0000_5000 && curStatus == 32'h0000_F0A2, "R10 outer context back",
            curPc, 32'h0000_5000);
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule